// File: doc/BRIEF.md
# Synchronous Fault Escalation Unit

This block stands between the fault sources of a nested vectored interrupt controller and its array of pending bits. Each request names an exception number to mark pending. Only the synchronous fault numbers are checked; all other exceptions and external interrupts pass through as themselves. A fault in that window is redirected to the hard-fault vector in two cases. The first is that its configured priority is not more urgent than the code now running. The second is that its enable bit is clear.

When a redirect is needed but the running priority is already negative, hard fault cannot be taken either. The block then reports lockup and leaves the pending bits alone. Each successful redirect sets a sticky "forced" status bit, which software clears by writing one. The set strobe doubles as the trigger for the priority resolver, so it fires only when the target vector was not already pending.

Top module: `fault_escalator`

## Requirements
- R1: A request for number 0..2 or 14 and above pends as itself, whatever its table priority and enable bit. `set_num` equals the request number.
- R2: A request for number 4..13 whose table priority (unsigned, 8 bits) is greater than or equal to `run_prio` (signed) is redirected. When `run_prio` is non-negative, `set_num` is 3.
- R3: A request for number 4..13 whose priority beats `run_prio` but whose enable bit is clear is redirected to 3 in the same way.
- R4: A request for number 4..13 that is enabled and whose priority is numerically below `run_prio` pends as itself.
- R5: A redirect that is needed while `run_prio` is negative gives a one-cycle `lockup` pulse instead. On that pulse there is no `set_vld` and `forced` is not changed. Number 3 itself carries fixed priority -1 and is always enabled, so a request for 3 locks up exactly when `run_prio` is -1 or lower.
- R6: Every successful redirect sets `forced`, including one whose target is already pending. `forced` then holds until it is cleared.
- R7: `forced_clr` high for one cycle clears `forced`. If a redirect happens in the same cycle, the set wins.
- R8: `set_vld` is raised only if bit `pend_state[target]` was low in the request cycle. A repeated request for a vector that is already pending gives no strobe.
- R9: `set_vld`, `set_num` and `lockup` are registered and appear on the clock edge that samples `req_valid`. A cycle without a request gives neither `set_vld` nor `lockup`.
- R10: While `rst_n` is low, `set_vld`, `lockup` and `forced` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Pend request strobe |
| req_num | input | 5 | Requested exception number |
| prio_table | input | 256 | Per-vector 8-bit priority; vector n at bits [8n+7:8n] |
| enable_table | input | 32 | Per-vector enable bit; vector n at bit n |
| run_prio | input | 10 | Current execution priority, signed |
| pend_state | input | 32 | Present pending bits, one per vector |
| forced_clr | input | 1 | Write-one-to-clear strobe for the forced bit |
| set_vld | output | 1 | Pend-set strobe and resolver update trigger |
| set_num | output | 5 | Vector number to set pending |
| lockup | output | 1 | One-cycle lockup indication |
| forced | output | 1 | Sticky forced-escalation status |

## Verification
Directed cases put the priority exactly at, just above and just below the running level. Those cases separate a `>=` comparison from a `>` comparison. They also separate a signed comparison from an unsigned one. Disabled-but-urgent faults separate the enable path from the priority path. Negative running levels, combined with requests for number 3 itself, separate lockup from a normal redirect. Random traffic mixes the window edges (2, 3, 13, 14), pending targets and clear strobes that collide with redirects. This checks the strobe suppression and the set-over-clear rule.

// File: rtl/fe_pkg.sv
package fe_pkg;
  typedef enum logic [1:0] {
    FE_IDLE = 2'd0,
    FE_SELF = 2'd1,
    FE_ESC  = 2'd2,
    FE_LOCK = 2'd3
  } fe_outcome_e;
endpackage

// File: rtl/fe_classify.sv
module fe_classify
  import fe_pkg::*;
#(
  parameter int NVEC    = 32,
  parameter int PRIO_W  = 8,
  parameter int HF_NUM  = 3,
  parameter int PSV_NUM = 14,
  localparam int NUM_W  = $clog2(NVEC),
  localparam int RUN_W  = PRIO_W + 2
) (
  input  logic                     req_valid,
  input  logic [NUM_W-1:0]         req_num,
  input  logic [NVEC*PRIO_W-1:0]   prio_table,
  input  logic [NVEC-1:0]          enable_table,
  input  logic signed [RUN_W-1:0]  run_prio,
  output fe_outcome_e              outcome,
  output logic [NUM_W-1:0]         target_num
);
  localparam logic [NUM_W-1:0] HF_IDX  = NUM_W'(HF_NUM);
  localparam logic [NUM_W-1:0] PSV_IDX = NUM_W'(PSV_NUM);

  logic                    in_window;
  logic                    is_hf;
  logic signed [RUN_W-1:0] vec_prio;
  logic                    vec_en;
  logic                    need_esc;

  always_comb begin
    in_window = (req_num >= HF_IDX) && (req_num < PSV_IDX);
    is_hf     = (req_num == HF_IDX);
    vec_prio  = is_hf ? -RUN_W'(1)
                      : $signed({2'b00, prio_table[req_num*PRIO_W +: PRIO_W]});
    vec_en    = is_hf | enable_table[req_num];
    need_esc  = in_window && ((vec_prio >= run_prio) || !vec_en);

    target_num = req_num;
    if (!req_valid) begin
      outcome = FE_IDLE;
    end else if (!need_esc) begin
      outcome = FE_SELF;
    end else if (run_prio < 0) begin
      outcome = FE_LOCK;
    end else begin
      outcome    = FE_ESC;
      target_num = HF_IDX;
    end
  end
endmodule

// File: rtl/fe_pend_gate.sv
module fe_pend_gate
  import fe_pkg::*;
#(
  parameter int NVEC   = 32,
  localparam int NUM_W = $clog2(NVEC)
) (
  input  fe_outcome_e      outcome,
  input  logic [NUM_W-1:0] target_num,
  input  logic [NVEC-1:0]  pend_state,
  output logic             set_nxt,
  output logic             lock_nxt
);
  always_comb begin
    set_nxt  = ((outcome == FE_SELF) || (outcome == FE_ESC)) && !pend_state[target_num];
    lock_nxt = (outcome == FE_LOCK);
  end
endmodule

// File: rtl/fe_sticky.sv
module fe_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_in,
  input  logic clr_in,
  output logic flag
);
  logic flag_nxt;
  logic flag_en;

  always_comb begin
    flag_en  = set_in | clr_in;
    flag_nxt = set_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (flag_en) flag <= flag_nxt;
  end
endmodule

// File: rtl/fault_escalator.sv
module fault_escalator
  import fe_pkg::*;
#(
  parameter int NVEC    = 32,
  parameter int PRIO_W  = 8,
  parameter int HF_NUM  = 3,
  parameter int PSV_NUM = 14,
  localparam int NUM_W  = $clog2(NVEC),
  localparam int RUN_W  = PRIO_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [NUM_W-1:0]         req_num,
  input  logic [NVEC*PRIO_W-1:0]   prio_table,
  input  logic [NVEC-1:0]          enable_table,
  input  logic signed [RUN_W-1:0]  run_prio,
  input  logic [NVEC-1:0]          pend_state,
  input  logic                     forced_clr,
  output logic                     set_vld,
  output logic [NUM_W-1:0]         set_num,
  output logic                     lockup,
  output logic                     forced
);
  fe_outcome_e      outcome;
  logic [NUM_W-1:0] target_num;
  logic             set_nxt;
  logic             lock_nxt;
  logic             esc_now;
  logic             num_en;

  fe_classify #(
    .NVEC(NVEC), .PRIO_W(PRIO_W), .HF_NUM(HF_NUM), .PSV_NUM(PSV_NUM)
  ) i_classify (
    .req_valid(req_valid), .req_num(req_num), .prio_table(prio_table),
    .enable_table(enable_table), .run_prio(run_prio),
    .outcome(outcome), .target_num(target_num)
  );

  fe_pend_gate #(.NVEC(NVEC)) i_gate (
    .outcome(outcome), .target_num(target_num), .pend_state(pend_state),
    .set_nxt(set_nxt), .lock_nxt(lock_nxt)
  );

  always_comb begin
    esc_now = (outcome == FE_ESC);
    num_en  = set_nxt;
  end

  fe_sticky i_forced (
    .clk(clk), .rst_n(rst_n), .set_in(esc_now), .clr_in(forced_clr), .flag(forced)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_vld <= 1'b0;
      lockup  <= 1'b0;
    end else begin
      set_vld <= set_nxt;
      lockup  <= lock_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      set_num <= '0;
    else if (num_en) set_num <= target_num;
  end
endmodule

// File: rtl/fe_checker.sv
module fe_checker #(
  parameter int NVEC    = 32,
  parameter int PRIO_W  = 8,
  parameter int HF_NUM  = 3,
  parameter int PSV_NUM = 14,
  localparam int NUM_W  = $clog2(NVEC),
  localparam int RUN_W  = PRIO_W + 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic [NUM_W-1:0]        req_num,
  input logic signed [RUN_W-1:0] run_prio,
  input logic [NVEC-1:0]         pend_state,
  input logic                    forced_clr,
  input logic                    set_vld,
  input logic [NUM_W-1:0]        set_num,
  input logic                    lockup,
  input logic                    forced
);
  logic outside;
  assign outside = (req_num < NUM_W'(HF_NUM)) || (req_num >= NUM_W'(PSV_NUM));

  p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && outside && !pend_state[req_num] |=> set_vld && (set_num == $past(req_num)));

  p_lock_no_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lockup |-> !set_vld);

  p_lock_neg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lockup |-> ($past(run_prio) < 0));

  p_forced_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    forced && !forced_clr |=> forced);

  p_no_repeat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && outside && pend_state[req_num] |=> !set_vld);

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !set_vld && !lockup);
endmodule

bind fault_escalator fe_checker #(
  .NVEC(NVEC), .PRIO_W(PRIO_W), .HF_NUM(HF_NUM), .PSV_NUM(PSV_NUM)
) i_fe_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_num(req_num),
  .run_prio(run_prio), .pend_state(pend_state), .forced_clr(forced_clr),
  .set_vld(set_vld), .set_num(set_num), .lockup(lockup), .forced(forced)
);

// File: tb/test_fault_escalator.sv
module test_fault_escalator;
  localparam int CLK_PERIOD = 10;

  logic         clk;
  logic         rst_n;
  logic         req_valid;
  logic [4:0]   req_num;
  logic [255:0] prio_table;
  logic [31:0]  enable_table;
  logic signed [9:0] run_prio;
  logic [31:0]  pend_state;
  logic         forced_clr;
  logic         set_vld;
  logic [4:0]   set_num;
  logic         lockup;
  logic         forced;

  logic [7:0] pr [32];
  logic       exp_forced;
  int         n_chk;
  int         n_bad;

  fault_escalator i_fault_escalator (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_num(req_num),
    .prio_table(prio_table), .enable_table(enable_table), .run_prio(run_prio),
    .pend_state(pend_state), .forced_clr(forced_clr), .set_vld(set_vld),
    .set_num(set_num), .lockup(lockup), .forced(forced)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < 32; i++) prio_table[i*8 +: 8] = pr[i];
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // outcome: 0 self, 1 redirect, 2 lockup
  function automatic int model(input int num, input int run);
    int  vp;
    bit  en;
    bit  esc;
    vp  = (num == 3) ? -1 : int'(pr[num]);
    en  = (num == 3) ? 1'b1 : enable_table[num];
    esc = (num >= 3) && (num < 14) && ((vp >= run) || !en);
    if (!esc) return 0;
    if (run < 0) return 2;
    return 1;
  endfunction

  task automatic apply(input string req, input int num, input int run, input bit clr);
    int oc;
    int tgt;
    bit exp_set;
    @(negedge clk);
    req_valid  = 1'b1;
    req_num    = 5'(num);
    run_prio   = 10'(run);
    forced_clr = clr;
    oc      = model(num, run);
    tgt     = (oc == 1) ? 3 : num;
    exp_set = (oc != 2) && !pend_state[tgt];
    if (oc == 1) exp_forced = 1'b1;
    else if (clr) exp_forced = 1'b0;
    @(negedge clk);
    req_valid  = 1'b0;
    forced_clr = 1'b0;
    check({req, " set_vld"}, int'(set_vld), int'(exp_set));
    if (exp_set) check({req, " set_num"}, int'(set_num), tgt);
    check({req, " lockup"}, int'(lockup), (oc == 2) ? 1 : 0);
    check({req, " forced"}, int'(forced), int'(exp_forced));
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0; exp_forced = 1'b0;
    void'($urandom(32'd1234));
    rst_n = 1'b0; req_valid = 1'b0; req_num = '0; run_prio = '0;
    pend_state = '0; forced_clr = 1'b0; enable_table = '1;
    for (int i = 0; i < 32; i++) pr[i] = 8'(i * 8);
    repeat (3) @(negedge clk);
    check("R10 set_vld", int'(set_vld), 0);
    check("R10 lockup", int'(lockup), 0);
    check("R10 forced", int'(forced), 0);
    rst_n = 1'b1;

    // R1: outside window, low urgency and disabled still pend as self
    pr[2] = 8'd255; enable_table[2] = 1'b0;
    apply("R1 num2", 2, 10, 0);
    pr[14] = 8'd255; enable_table[14] = 1'b0;
    apply("R1 num14", 14, 10, 0);
    // R4: enabled, more urgent
    pr[5] = 8'd9;
    apply("R4 below", 5, 10, 0);
    // R2: equal priority redirects
    pr[6] = 8'd10;
    apply("R2 equal", 6, 10, 0);
    // R7: clear, then set wins over clear
    apply("R7 clear", 20, 10, 1);
    pr[13] = 8'd200;
    apply("R7 setwins", 13, 10, 1);
    apply("R7 clear2", 1, 10, 1);
    // R3: disabled but urgent
    pr[4] = 8'd1; enable_table[4] = 1'b0;
    apply("R3 disabled", 4, 10, 0);
    // R6: redirect with target already pending still sets forced
    apply("R6 clr", 0, 10, 1);
    pend_state[3] = 1'b1;
    apply("R6 hfpend", 6, 10, 0);
    apply("R6 hold", 5, 10, 0);
    pend_state[3] = 1'b0;
    // R5: lockup for negative running priority
    apply("R5 clr", 0, 10, 1);
    apply("R5 lock", 6, -1, 0);
    apply("R5 hf-1", 3, -1, 0);
    apply("R5 hf-2", 3, -2, 0);
    apply("R5 hfok", 3, 0, 0);
    // R8: repeated request to a pending vector
    pend_state[5] = 1'b1;
    apply("R8 pend", 5, 10, 0);
    pend_state[5] = 1'b0;
    // R9: idle cycle
    @(negedge clk);
    check("R9 idle set", int'(set_vld), 0);
    check("R9 idle lock", int'(lockup), 0);

    for (int k = 0; k < 400; k++) begin
      int num;
      int run;
      for (int i = 0; i < 32; i++) pr[i] = 8'($urandom_range(0, 40));
      enable_table = $urandom;
      pend_state   = $urandom & $urandom;
      num = ($urandom_range(0, 3) == 0) ? int'($urandom_range(2, 3)) + 11 * int'($urandom_range(0, 1))
                                        : int'($urandom_range(0, 31));
      run = int'($urandom_range(0, 42)) - 2;
      apply("R2 rand", num, run, ($urandom_range(0, 7) == 0));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule